// File: doc/BRIEF.md
# Interrupt-to-Message Aggregator

This block gathers eleven level-sensitive interrupt lines into one register-mapped controller. For every line it keeps four things: the live input level, a sticky pending bit, a mask bit and a steering bit. The controller signals the processor with a memory write instead of a dedicated wire. When a masked-in line goes from low to high, the block queues one 32-bit posted write. The address and data of that write come from one of two programmable target registers, and the line's steering bit chooses which one.

Software reaches the block through a simple register port. A read returns its data in the same cycle it is requested, and a write takes effect at the next clock edge. The pending register is cleared by any read of it and by any write to it. Two read-only request views combine level, mask and steering, one view for each target. Message writes go out on a request/acknowledge master port. One write is in flight at a time. When several lines are waiting, the lowest-numbered line is sent first.

The line assignment is as follows. Lines 0 to 5 are the six shared PCI interrupt pins. Line 6 is the external system-bus interrupt. Line 7 is the non-fatal bus-error source. Line 8 is the PS/2 controller. Line 9 is unused. Line 10 is the serial port.

Top module: `irq_msg_agg`

## Requirements
- R1: The level register (offset 0x028, bits 10:0) reads back the value of `lineIn` sampled at the previous clock edge.
- R2: Writes to the level register (0x028) and to the two request views (0x00C, 0x014) have no effect on any register.
- R3: When a line is high while its level bit is 0, its bit is ORed into the pending register (0x01C, bits 10:0). Mask and steering do not affect this.
- R4: A read of the pending register returns its value and then clears it. Any write to it clears it whatever the data. A rising edge in the same cycle as such an access stays set.
- R5: A rising edge on a line whose mask bit (0x018) is 1 produces exactly one write on the master port. A masked-off line produces none.
- R6: The write uses the target chosen by the line's steering bit (0x024) at the edge: 0 selects target 0 (0x004) and 1 selects target 1 (0x010). The value used is that target's contents at launch. The address is that value with bits 4:0 cleared, and the data word is bits 4:0 of that value, zero-extended.
- R7: Request view 0 (0x00C) reads level AND mask AND NOT steering. Request view 1 (0x014) reads level AND mask AND steering.
- R8: Targets are 32-bit read/write registers. Mask and steering are 11-bit read/write registers that read as zero above bit 10.
- R9: `msgReq` stays high with stable `msgAddr` and `msgData` until the cycle `msgAck` is high. Queued writes are launched lowest line first, and none is lost.
- R10: Reset clears every register and drops `msgReq`. A read of an unmapped offset returns 0.
- R11: A new rising edge of a line whose write is still queued and not yet launched merges into that write. The steering bit at the newest edge decides the target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lineIn | input | 11 | Interrupt source levels |
| regAddr | input | 12 | Register byte offset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data, same cycle as regRdEn |
| msgReq | output | 1 | Message write request |
| msgAddr | output | 32 | Message write address |
| msgData | output | 32 | Message write data |
| msgAck | input | 1 | Message write accepted |

## Verification
Two collisions are provoked on purpose.

The first is a pending-register access that lands in the same cycle as a fresh edge on a line. The bench drives a pending read together with a rising line. It then checks that the read returned the old contents, and that a second read shows only the new bit.

The second is a launch that collides with a new edge on the same line, or with several lines rising together while the master port is held off. All eleven lines are raised in one cycle with acknowledge withheld. The bench then releases acknowledge and judges each write in turn against a behavioural queue model, which decides the order and the address/data values on every clock.

// File: rtl/irq_msg_agg_pkg.sv
package irq_msg_agg_pkg;

  localparam logic [11:0] OFF_TGT0  = 12'h004;
  localparam logic [11:0] OFF_VIEW0 = 12'h00C;
  localparam logic [11:0] OFF_TGT1  = 12'h010;
  localparam logic [11:0] OFF_VIEW1 = 12'h014;
  localparam logic [11:0] OFF_MASK  = 12'h018;
  localparam logic [11:0] OFF_PEND  = 12'h01C;
  localparam logic [11:0] OFF_STEER = 12'h024;
  localparam logic [11:0] OFF_LEVEL = 12'h028;

  typedef struct packed {
    logic wrTgt0;
    logic wrTgt1;
    logic wrMask;
    logic wrSteer;
    logic clrPend;
    logic launch;
  } aggStrobe_t;

  typedef enum logic [3:0] {
    RS_NONE, RS_TGT0, RS_VIEW0, RS_TGT1, RS_VIEW1,
    RS_MASK, RS_PEND, RS_STEER, RS_LEVEL
  } rdSel_e;

endpackage

// File: rtl/irq_msg_agg_ctrl.sv
module irq_msg_agg_ctrl
  import irq_msg_agg_pkg::*;
#(
  parameter int unsigned NSRC = 11,
  parameter int unsigned AW   = 12
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [AW-1:0]   regAddr,
  input  logic            regWrEn,
  input  logic            regRdEn,
  input  logic [NSRC-1:0] msgQueue,
  input  logic            msgAck,
  output aggStrobe_t      strb,
  output logic [NSRC-1:0] launchOh,
  output rdSel_e          rdSel,
  output logic            msgReq
);

  typedef enum logic {ST_IDLE, ST_BUSY} sendSt_e;

  sendSt_e stQ, stD;
  logic    canLaunch;
  logic [NSRC-1:0] lowestOh;

  function automatic logic hit(input logic [AW-1:0] a, input logic [11:0] off);
    return a == AW'(off);
  endfunction

  // lowest set bit wins
  assign lowestOh  = msgQueue & (~msgQueue + NSRC'(1));
  assign canLaunch = (stQ == ST_IDLE) && (|msgQueue);
  assign launchOh  = canLaunch ? lowestOh : '0;

  always_comb begin
    stD = stQ;
    case (stQ)
      ST_IDLE: if (canLaunch) stD = ST_BUSY;
      ST_BUSY: if (msgAck)    stD = ST_IDLE;
      default: stD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stQ <= ST_IDLE;
    else       stQ <= stD;
  end

  assign msgReq = (stQ == ST_BUSY);

  always_comb begin
    strb         = '0;
    strb.launch  = canLaunch;
    strb.wrTgt0  = regWrEn && hit(regAddr, OFF_TGT0);
    strb.wrTgt1  = regWrEn && hit(regAddr, OFF_TGT1);
    strb.wrMask  = regWrEn && hit(regAddr, OFF_MASK);
    strb.wrSteer = regWrEn && hit(regAddr, OFF_STEER);
    strb.clrPend = (regWrEn || regRdEn) && hit(regAddr, OFF_PEND);
  end

  always_comb begin
    rdSel = RS_NONE;
    if (regRdEn) begin
      if      (hit(regAddr, OFF_TGT0))  rdSel = RS_TGT0;
      else if (hit(regAddr, OFF_VIEW0)) rdSel = RS_VIEW0;
      else if (hit(regAddr, OFF_TGT1))  rdSel = RS_TGT1;
      else if (hit(regAddr, OFF_VIEW1)) rdSel = RS_VIEW1;
      else if (hit(regAddr, OFF_MASK))  rdSel = RS_MASK;
      else if (hit(regAddr, OFF_PEND))  rdSel = RS_PEND;
      else if (hit(regAddr, OFF_STEER)) rdSel = RS_STEER;
      else if (hit(regAddr, OFF_LEVEL)) rdSel = RS_LEVEL;
    end
  end

endmodule

// File: rtl/irq_msg_agg_dp.sv
module irq_msg_agg_dp
  import irq_msg_agg_pkg::*;
#(
  parameter int unsigned NSRC  = 11,
  parameter int unsigned DW    = 32,
  parameter int unsigned ALIGN = 5
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [NSRC-1:0] lineIn,
  input  logic [DW-1:0]   regWrData,
  input  aggStrobe_t      strb,
  input  logic [NSRC-1:0] launchOh,
  input  rdSel_e          rdSel,
  output logic [DW-1:0]   regRdData,
  output logic [NSRC-1:0] msgQueue,
  output logic [DW-1:0]   msgAddr,
  output logic [DW-1:0]   msgData
);

  localparam int unsigned PAD = DW - NSRC;

  logic [DW-1:0]   tgt0Q, tgt1Q, selTgt, outAddrQ, outDataQ;
  logic [NSRC-1:0] maskQ, steerQ, lvlQ, pendQ, queueQ, snapQ;
  logic [NSRC-1:0] edgeVec, newMsg, view0, view1;
  logic            useTgt1;

  assign edgeVec = lineIn & ~lvlQ;
  assign newMsg  = edgeVec & maskQ;
  assign view0   = lvlQ & maskQ & ~steerQ;
  assign view1   = lvlQ & maskQ & steerQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lvlQ  <= '0;
      pendQ <= '0;
    end else begin
      lvlQ  <= lineIn;
      pendQ <= strb.clrPend ? edgeVec : (pendQ | edgeVec);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tgt0Q  <= '0;
      tgt1Q  <= '0;
      maskQ  <= '0;
      steerQ <= '0;
    end else begin
      if (strb.wrTgt0)  tgt0Q  <= regWrData;
      if (strb.wrTgt1)  tgt1Q  <= regWrData;
      if (strb.wrMask)  maskQ  <= regWrData[NSRC-1:0];
      if (strb.wrSteer) steerQ <= regWrData[NSRC-1:0];
    end
  end

  // one queue slot per line, with the steering captured at the edge
  for (genvar gi = 0; gi < NSRC; gi++) begin : g_slot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        queueQ[gi] <= 1'b0;
        snapQ[gi]  <= 1'b0;
      end else if (newMsg[gi]) begin
        queueQ[gi] <= 1'b1;
        snapQ[gi]  <= steerQ[gi];
      end else if (launchOh[gi]) begin
        queueQ[gi] <= 1'b0;
      end
    end
  end

  assign msgQueue = queueQ;
  assign useTgt1  = |(launchOh & snapQ);
  assign selTgt   = useTgt1 ? tgt1Q : tgt0Q;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outAddrQ <= '0;
      outDataQ <= '0;
    end else if (strb.launch) begin
      outAddrQ <= {selTgt[DW-1:ALIGN], {ALIGN{1'b0}}};
      outDataQ <= {{(DW-ALIGN){1'b0}}, selTgt[ALIGN-1:0]};
    end
  end

  assign msgAddr = outAddrQ;
  assign msgData = outDataQ;

  always_comb begin
    case (rdSel)
      RS_TGT0:  regRdData = tgt0Q;
      RS_TGT1:  regRdData = tgt1Q;
      RS_VIEW0: regRdData = {{PAD{1'b0}}, view0};
      RS_VIEW1: regRdData = {{PAD{1'b0}}, view1};
      RS_MASK:  regRdData = {{PAD{1'b0}}, maskQ};
      RS_PEND:  regRdData = {{PAD{1'b0}}, pendQ};
      RS_STEER: regRdData = {{PAD{1'b0}}, steerQ};
      RS_LEVEL: regRdData = {{PAD{1'b0}}, lvlQ};
      default:  regRdData = '0;
    endcase
  end

endmodule

// File: rtl/irq_msg_agg.sv
module irq_msg_agg
  import irq_msg_agg_pkg::*;
#(
  parameter int unsigned NSRC  = 11,
  parameter int unsigned DW    = 32,
  parameter int unsigned AW    = 12,
  parameter int unsigned ALIGN = 5
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [NSRC-1:0] lineIn,
  input  logic [AW-1:0]   regAddr,
  input  logic            regWrEn,
  input  logic            regRdEn,
  input  logic [DW-1:0]   regWrData,
  output logic [DW-1:0]   regRdData,
  output logic            msgReq,
  output logic [DW-1:0]   msgAddr,
  output logic [DW-1:0]   msgData,
  input  logic            msgAck
);

  aggStrobe_t      strb;
  rdSel_e          rdSel;
  logic [NSRC-1:0] launchOh;
  logic [NSRC-1:0] msgQueue;

  irq_msg_agg_ctrl #(.NSRC(NSRC), .AW(AW)) ctrlI (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regRdEn(regRdEn), .msgQueue(msgQueue), .msgAck(msgAck),
    .strb(strb), .launchOh(launchOh), .rdSel(rdSel), .msgReq(msgReq)
  );

  irq_msg_agg_dp #(.NSRC(NSRC), .DW(DW), .ALIGN(ALIGN)) dpI (
    .clk(clk), .rstN(rstN), .lineIn(lineIn), .regWrData(regWrData),
    .strb(strb), .launchOh(launchOh), .rdSel(rdSel),
    .regRdData(regRdData), .msgQueue(msgQueue),
    .msgAddr(msgAddr), .msgData(msgData)
  );

endmodule

// File: rtl/irq_msg_agg_chk.sv
module irq_msg_agg_chk
  import irq_msg_agg_pkg::*;
#(
  parameter int unsigned NSRC  = 11,
  parameter int unsigned DW    = 32,
  parameter int unsigned AW    = 12,
  parameter int unsigned ALIGN = 5
) (
  input logic            clk,
  input logic            rstN,
  input logic [NSRC-1:0] lineIn,
  input logic [AW-1:0]   regAddr,
  input logic            regRdEn,
  input logic [DW-1:0]   regRdData,
  input logic            msgReq,
  input logic [DW-1:0]   msgAddr,
  input logic [DW-1:0]   msgData,
  input logic            msgAck,
  input logic [NSRC-1:0] msgQueue,
  input logic [NSRC-1:0] launchOh
);

  logic pastOk;
  logic rdLevel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastOk <= 1'b0;
    else       pastOk <= 1'b1;
  end

  assign rdLevel = regRdEn && (regAddr == AW'(OFF_LEVEL));

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (msgReq && !msgAck) |=> (msgReq && $stable(msgAddr) && $stable(msgData)));

  // R6
  addr_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    msgReq |-> (msgAddr[ALIGN-1:0] == '0) && (msgData[DW-1:ALIGN] == '0));

  // R1
  level_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdLevel && pastOk) |-> (regRdData == DW'($past(lineIn))));

  // R5
  req_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(msgReq) |-> $past(msgQueue != '0));

  // R9
  single_launch_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(launchOh) && ((launchOh & ~msgQueue) == '0));

endmodule

bind irq_msg_agg irq_msg_agg_chk #(.NSRC(NSRC), .DW(DW), .AW(AW), .ALIGN(ALIGN)) chkI (
  .clk(clk), .rstN(rstN), .lineIn(lineIn), .regAddr(regAddr),
  .regRdEn(regRdEn), .regRdData(regRdData), .msgReq(msgReq),
  .msgAddr(msgAddr), .msgData(msgData), .msgAck(msgAck),
  .msgQueue(msgQueue), .launchOh(launchOh)
);

// File: tb/irq_msg_agg_tb_top.sv
module irq_msg_agg_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [10:0] lineIn = '0;
  logic [11:0] regAddr = '0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData, msgAddr, msgData;
  logic        msgReq;
  logic        msgAck = 1'b0;

  int nCmp = 0, nBad = 0;
  bit finished = 0;
  int ackMode = 0;
  string ovr = "";

  always #10 clk = ~clk;

  irq_msg_agg dut_i (
    .clk(clk), .rstN(rstN), .lineIn(lineIn), .regAddr(regAddr),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regWrData(regWrData),
    .regRdData(regRdData), .msgReq(msgReq), .msgAddr(msgAddr),
    .msgData(msgData), .msgAck(msgAck)
  );

  // behavioural reference state
  logic [31:0] mT0 = '0, mT1 = '0, mAddr = '0, mData = '0;
  logic [10:0] mMask = '0, mSteer = '0, mLvl = '0, mPend = '0, mQ = '0, mSnap = '0;
  bit          mBusy = 0;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mT0 = '0; mT1 = '0; mAddr = '0; mData = '0;
      mMask = '0; mSteer = '0; mLvl = '0; mPend = '0; mQ = '0; mSnap = '0;
      mBusy = 0;
    end else begin
      logic [10:0] edges, nQ, nSnap;
      logic [31:0] t;
      edges = lineIn & ~mLvl;
      nQ = mQ; nSnap = mSnap;
      if (!mBusy && mQ != 0) begin
        for (int i = 0; i < 11; i++) begin
          if (mQ[i]) begin
            t = mSnap[i] ? mT1 : mT0;
            mAddr = t & ~32'h1F;
            mData = t & 32'h1F;
            nQ[i] = 1'b0;
            break;
          end
        end
        mBusy = 1;
      end else if (mBusy && msgAck) begin
        mBusy = 0;
      end
      for (int i = 0; i < 11; i++)
        if (edges[i] && mMask[i]) begin nQ[i] = 1'b1; nSnap[i] = mSteer[i]; end
      mQ = nQ; mSnap = nSnap;
      if ((regRdEn || regWrEn) && regAddr == 12'h01C) mPend = edges;
      else mPend = mPend | edges;
      if (regWrEn) begin
        case (regAddr)
          12'h004: mT0 = regWrData;
          12'h010: mT1 = regWrData;
          12'h018: mMask = regWrData[10:0];
          12'h024: mSteer = regWrData[10:0];
          default: ;
        endcase
      end
      mLvl = lineIn;
    end
  end

  function automatic logic [31:0] expRd();
    if (!regRdEn) return '0;
    case (regAddr)
      12'h004: return mT0;
      12'h010: return mT1;
      12'h00C: return {21'b0, mLvl & mMask & ~mSteer};
      12'h014: return {21'b0, mLvl & mMask & mSteer};
      12'h018: return {21'b0, mMask};
      12'h01C: return {21'b0, mPend};
      12'h024: return {21'b0, mSteer};
      12'h028: return {21'b0, mLvl};
      default: return '0;
    endcase
  endfunction

  function automatic string rdTag();
    case (regAddr)
      12'h00C, 12'h014: return "R7";
      12'h01C:          return "R4";
      12'h028:          return "R1";
      12'h004, 12'h010, 12'h018, 12'h024: return "R8";
      default:          return "R10";
    endcase
  endfunction

  task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
    string t;
    t = (ovr != "") ? ovr : tag;
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s act=%h exp=%h at %0t", t, act, exp, $time);
    end
  endtask

  task automatic checkNow();
    cmp("R5", {31'b0, msgReq}, {31'b0, mBusy});
    if (mBusy) begin
      cmp("R6", msgAddr, mAddr);
      cmp("R6", msgData, mData);
    end
    if (regRdEn) cmp(rdTag(), regRdData, expRd());
  endtask

  task automatic step(input logic [10:0] ln, input bit rd, input bit wr,
                      input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    lineIn = ln; regRdEn = rd; regWrEn = wr; regAddr = a; regWrData = d;
    case (ackMode)
      1: msgAck = msgReq;
      2: msgAck = 1'b0;
      default: msgAck = msgReq && ($urandom % 3 == 0);
    endcase
    #1 checkNow();
  endtask

  initial begin
    logic [11:0] offs [10];
    offs = '{12'h004, 12'h00C, 12'h010, 12'h014, 12'h018,
             12'h01C, 12'h024, 12'h028, 12'h030, 12'h008};
    // R10: reset state
    ovr = "R10";
    for (int i = 0; i < 3; i++) step('0, 1, 0, offs[i*3], '0);
    rstN = 1'b1;
    for (int i = 0; i < 10; i++) step('0, 1, 0, offs[i], '0);
    // R8: register programming and readback
    ovr = "R8";
    ackMode = 1;
    step('0, 0, 1, 12'h004, 32'h1234_5667);
    step('0, 0, 1, 12'h010, 32'hABCD_EF3F);
    step('0, 0, 1, 12'h018, 32'hFFFF_F7F7);
    step('0, 0, 1, 12'h024, 32'h0000_00A5);
    for (int i = 0; i < 10; i++) step('0, 1, 0, offs[i], '0);
    // R2: writes to read-only registers ignored
    ovr = "R2";
    step('0, 0, 1, 12'h028, 32'hFFFF_FFFF);
    step('0, 0, 1, 12'h00C, 32'hFFFF_FFFF);
    step('0, 0, 1, 12'h014, 32'hFFFF_FFFF);
    for (int i = 0; i < 8; i++) step('0, 1, 0, offs[i], '0);
    // R3: masked-off line 3 still sets pending, no message
    ovr = "R3";
    step(11'h008, 0, 0, '0, '0);
    step(11'h008, 1, 0, 12'h01C, '0);
    step(11'h008, 1, 0, 12'h01C, '0);
    step('0, 1, 0, 12'h028, '0);
    // R9: all lines at once, port held off, then drained in order
    ovr = "R9";
    ackMode = 2;
    step(11'h7FF, 0, 0, '0, '0);
    for (int i = 0; i < 5; i++) step(11'h7FF, 1, 0, 12'h00C, '0);
    ackMode = 1;
    for (int i = 0; i < 40; i++) step(11'h7FF, 1, 0, 12'h014, '0);
    // R4: pending access colliding with a new edge
    ovr = "R4";
    step('0, 1, 0, 12'h01C, '0);
    step(11'h001, 1, 0, 12'h01C, '0);
    step(11'h001, 1, 0, 12'h01C, '0);
    step(11'h003, 0, 1, 12'h01C, 32'hFFFF_FFFF);
    step(11'h003, 1, 0, 12'h01C, '0);
    for (int i = 0; i < 6; i++) step('0, 0, 0, '0, '0);
    // R11: repeat edge merged while queued, steering changed in between
    ovr = "R11";
    ackMode = 2;
    step(11'h004, 0, 0, '0, '0);
    step(11'h000, 0, 1, 12'h024, 32'h0000_0004);
    step(11'h004, 0, 0, '0, '0);
    step(11'h000, 0, 0, '0, '0);
    ackMode = 1;
    for (int i = 0; i < 8; i++) step('0, 0, 0, '0, '0);
    // R7: request views with mixed levels
    ovr = "R7";
    step(11'h5A3, 1, 0, 12'h00C, '0);
    for (int i = 0; i < 6; i++) step(11'h5A3, 1, 0, (i % 2) ? 12'h014 : 12'h00C, '0);
    // random mix
    ovr = "";
    ackMode = 0;
    for (int i = 0; i < 6000; i++) begin
      logic [10:0] ln;
      int kind;
      ln = ($urandom % 8 == 0) ? 11'($urandom) : lineIn ^ (11'(1) << ($urandom % 11));
      kind = $urandom % 4;
      if (kind == 0)
        step(ln, 0, 1, offs[$urandom % 10], $urandom);
      else
        step(ln, kind != 1, 0, offs[$urandom % 10], '0);
    end
    ackMode = 1;
    for (int i = 0; i < 40; i++) step('0, 1, 0, 12'h01C, '0);
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nCmp++;
      nBad++;
      $display("FAIL watchdog R9 act=running exp=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

endmodule